// File: doc/BRIEF.md
# Packed-Decimal Adder with Carry Chain

This block adds two packed binary-coded-decimal operands and an incoming carry flag, one decimal digit at a time. Every 4-bit digit adds its two nibbles and the carry from the digit below it. When that digit sum passes nine, the digit is corrected by six and a carry passes to the next digit up. The block is purely combinational and is meant to sit in the execute stage of a small processor datapath, next to the binary adder.

A single select input sets the width. In word mode all digits take part. In byte mode only the lower half of the digits are used, and the upper half of the result is forced to zero, as a register destination would hold it. The outputs are the decimal result and the carry, zero and negative flags. The overflow flag carries no meaning for decimal addition, so it is tied low, which keeps results deterministic. If a source operand of zero is applied, the block simply adds the carry to the destination.

Top module: `bcd_dec_adder`

## Requirements
- R1: With `half_i`=0 and operands made of valid digits (0-9), `sum_o` is the decimal value dst + src + carry_i modulo 10^DIGITS, written as packed digits with digit 0 in bits 3:0.
- R2: With `half_i`=0, `carry_o` is 1 exactly when dst + src + carry_i, taken as decimal numbers, exceeds 10^DIGITS - 1 (9999 for four digits).
- R3: With `half_i`=1 (byte mode), only the lower DIGITS/2 digits of each operand are used: the lower half of `sum_o` is their decimal sum plus carry_i modulo 10^(DIGITS/2), and the upper half of `sum_o` is zero whatever the upper operand digits are.
- R4: With `half_i`=1, `carry_o` is 1 exactly when the lower-half decimal sum plus carry_i exceeds 10^(DIGITS/2) - 1 (99 for two digits).
- R5: `zero_o` is 1 exactly when `sum_o` is all zeros.
- R6: `neg_o` equals the top bit of the active width: bit 4*DIGITS-1 in word mode, bit 2*DIGITS-1 in byte mode.
- R7: `ovf_o` is always 0.
- R8: With `src_i` = 0, the result is dst + carry_i, so carry_i = 1 increments the destination by one decimal count and carry_i = 0 returns it unchanged.
- R9: For nibbles above 9 the result stays defined: each digit forms s = dst nibble + src nibble + incoming carry; if s > 9 the digit is (s + 6) mod 16 and its carry out is 1, otherwise the digit is s and its carry out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dst_i | input | 4*DIGITS | Destination operand, packed digits |
| src_i | input | 4*DIGITS | Source operand, packed digits |
| carry_i | input | 1 | Incoming carry flag |
| half_i | input | 1 | 1 selects byte mode (lower half of the digits), 0 selects word mode |
| sum_o | output | 4*DIGITS | Packed decimal result |
| carry_o | output | 1 | Decimal carry out of the active width |
| zero_o | output | 1 | Result is zero |
| neg_o | output | 1 | Top bit of the active width |
| ovf_o | output | 1 | Overflow flag, held at 0 |

## Verification
The bench uses the default DIGITS = 4. That gives a 16-bit word mode and an 8-bit byte mode, so both thresholds, 9999 and 99, can be reached with exhaustive-style corner operands such as 9999 + 9999 + 1. Random valid-digit operands are compared against a decimal-integer model. Random arbitrary nibbles are compared against a per-digit model, which exercises the correction rule for digits above nine.

// File: rtl/bcd_dec_adder.sv
module bcd_dec_adder #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] dst_i,
  input  logic [4*DIGITS-1:0] src_i,
  input  logic                carry_i,
  input  logic                half_i,
  output logic [4*DIGITS-1:0] sum_o,
  output logic                carry_o,
  output logic                zero_o,
  output logic                neg_o,
  output logic                ovf_o
);
  localparam int W    = 4 * DIGITS;
  localparam int HALF = DIGITS / 2;
  localparam int HW   = 4 * HALF;

  logic [W-1:0] raw;
  logic         c_full;
  logic         c_half;

  always_comb begin
    logic [4:0] s;
    logic       c;
    c      = carry_i;
    c_half = 1'b0;
    raw    = '0;
    for (int d = 0; d < DIGITS; d++) begin
      s = {1'b0, dst_i[4*d +: 4]} + {1'b0, src_i[4*d +: 4]} + {4'b0, c};
      c = (s > 5'd9);
      if (c) s = s + 5'd6;
      raw[4*d +: 4] = s[3:0];
      if (d == HALF - 1) c_half = c;
    end
    c_full = c;
  end

  assign sum_o   = half_i ? {{(W-HW){1'b0}}, raw[HW-1:0]} : raw;
  assign carry_o = half_i ? c_half : c_full;
  assign zero_o  = half_i ? (raw[HW-1:0] == '0) : (raw == '0);
  assign neg_o   = half_i ? raw[HW-1] : raw[W-1];
  assign ovf_o   = 1'b0;
endmodule

// File: rtl/bcd_dec_adder_chk.sv
module bcd_dec_adder_chk #(
  parameter int DIGITS = 4
) (
  input logic [4*DIGITS-1:0] dst_i,
  input logic [4*DIGITS-1:0] src_i,
  input logic                carry_i,
  input logic                half_i,
  input logic [4*DIGITS-1:0] sum_o,
  input logic                carry_o,
  input logic                zero_o,
  input logic                neg_o,
  input logic                ovf_o
);
  localparam int W  = 4 * DIGITS;
  localparam int HW = 4 * (DIGITS / 2);

  function automatic bit all_valid(input logic [W-1:0] v);
    bit ok = 1'b1;
    for (int d = 0; d < DIGITS; d++)
      if (v[4*d +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  function automatic longint to_dec(input logic [W-1:0] v);
    longint acc = 0;
    for (int d = DIGITS - 1; d >= 0; d--)
      acc = acc * 10 + longint'(v[4*d +: 4]);
    return acc;
  endfunction

  function automatic longint top_val();
    longint t = 1;
    for (int d = 0; d < DIGITS; d++) t = t * 10;
    return t;
  endfunction

  always_comb begin
    if (half_i)
      p_upper_clear_r3: assert (sum_o[W-1:HW] == '0);
    p_zero_flag_r5: assert (zero_o == (sum_o == '0));
    p_neg_flag_r6: assert (neg_o == (half_i ? sum_o[HW-1] : sum_o[W-1]));
    p_no_overflow_r7: assert (ovf_o == 1'b0);
    if (!half_i && all_valid(dst_i) && all_valid(src_i))
      p_word_carry_r2: assert (carry_o ==
        ((to_dec(dst_i) + to_dec(src_i) + longint'(carry_i)) >= top_val()));
  end
endmodule

bind bcd_dec_adder bcd_dec_adder_chk #(.DIGITS(DIGITS)) u_chk (.*);

// File: tb/bcd_dec_adder_test.sv
module bcd_dec_adder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] dst, src;
  logic        cin, half;
  logic [15:0] sum;
  logic        cout, zf, nf, vf;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  bcd_dec_adder uut (
    .dst_i(dst), .src_i(src), .carry_i(cin), .half_i(half),
    .sum_o(sum), .carry_o(cout), .zero_o(zf), .neg_o(nf), .ovf_o(vf)
  );

  function automatic logic [16:0] nib_model(input logic [15:0] a, input logic [15:0] b,
                                            input logic ci, input logic h);
    logic [15:0] r = '0;
    logic        c = ci;
    logic        ch = 1'b0;
    for (int d = 0; d < 4; d++) begin
      int s = int'(a[4*d +: 4]) + int'(b[4*d +: 4]) + int'(c);
      c = (s > 9);
      r[4*d +: 4] = c ? 4'((s + 6) % 16) : 4'(s);
      if (d == 1) ch = c;
    end
    return h ? {ch, 8'h00, r[7:0]} : {c, r};
  endfunction

  function automatic int to_int(input logic [15:0] v, input int nd);
    int acc = 0;
    for (int d = nd - 1; d >= 0; d--) acc = acc * 10 + int'(v[4*d +: 4]);
    return acc;
  endfunction

  function automatic logic [15:0] to_bcd(input int v);
    logic [15:0] r = '0;
    for (int d = 0; d < 4; d++) begin
      r[4*d +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic logic [15:0] rnd_bcd();
    return to_bcd(int'($urandom % 10000));
  endfunction

  task automatic check(input string req, input string what, input logic [16:0] got, input logic [16:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (dst=%h src=%h c=%b half=%b)",
               req, what, got, exp, dst, src, cin, half);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic ci, input logic h);
    @(negedge clk);
    dst = a; src = b; cin = ci; half = h;
    @(posedge clk);
    #1;
  endtask

  task automatic full_check(input string req);
    logic [16:0] e = nib_model(dst, src, cin, half);
    check(req, "sum/carry", {cout, sum}, e);
    check("R5", "zero", {16'b0, zf}, {16'b0, e[15:0] == 16'h0});
    check("R6", "neg", {16'b0, nf}, {16'b0, half ? e[7] : e[15]});
    check("R7", "ovf", {16'b0, vf}, 17'b0);
  endtask

  task automatic dec_check(input string req);
    int nd = half ? 2 : 4;
    int lim = half ? 100 : 10000;
    int t = to_int(dst, nd) + to_int(src, nd) + int'(cin);
    logic [15:0] e = to_bcd(t % lim);
    check(req, "decimal", {cout, sum}, {t >= lim, e});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    dst = '0; src = '0; cin = 1'b0; half = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5", "reset zero", {16'b0, zf}, 17'h1);
    check("R1", "reset sum", {cout, sum}, 17'h0);

    apply(16'h1238, 16'h7684, 1'b0, 1'b0);
    check("R1", "word example", {cout, sum}, {1'b0, 16'h8922});
    apply(16'h1238, 16'h7684, 1'b0, 1'b1);
    check("R4", "byte example", {cout, sum}, {1'b1, 16'h0022});
    apply(16'h9999, 16'h0001, 1'b0, 1'b0);
    check("R2", "word wrap", {cout, sum, zf}, {1'b1, 16'h0000, 1'b1});
    apply(16'h9999, 16'h9999, 1'b1, 1'b0);
    check("R2", "word max", {cout, sum}, {1'b1, 16'h9999});
    apply(16'h9998, 16'h0001, 1'b0, 1'b0);
    check("R2", "word no carry", {cout, sum}, {1'b0, 16'h9999});
    apply(16'h5599, 16'h4400, 1'b1, 1'b1);
    check("R3", "byte upper cleared", {cout, sum, zf}, {1'b1, 16'h0000, 1'b1});
    apply(16'h0098, 16'h0001, 1'b0, 1'b1);
    check("R4", "byte no carry", {cout, sum}, {1'b0, 16'h0099});
    apply(16'h0459, 16'h0000, 1'b1, 1'b0);
    check("R8", "add carry", {cout, sum}, {1'b0, 16'h0460});
    apply(16'h3071, 16'h0000, 1'b0, 1'b0);
    check("R8", "carry clear", {cout, sum}, {1'b0, 16'h3071});
    apply(16'h8000, 16'h0000, 1'b0, 1'b0);
    check("R6", "word neg", {16'b0, nf}, 17'h1);
    apply(16'h0080, 16'h0000, 1'b0, 1'b1);
    check("R6", "byte neg", {16'b0, nf}, 17'h1);
    apply(16'h0080, 16'h0000, 1'b0, 1'b0);
    check("R6", "word bit7 ignored", {16'b0, nf}, 17'h0);
    apply(16'h000F, 16'h000F, 1'b1, 1'b0);
    check("R9", "nibble 31", {cout, sum}, {1'b0, 16'h0015});
    apply(16'h00A0, 16'h0000, 1'b0, 1'b1);
    check("R9", "nibble A", {cout, sum}, {1'b1, 16'h0000});

    for (int i = 0; i < 400; i++) begin
      apply(rnd_bcd(), rnd_bcd(), 1'($urandom), 1'($urandom));
      dec_check(half ? "R3" : "R1");
      full_check(half ? "R4" : "R2");
    end
    for (int i = 0; i < 100; i++) begin
      apply(rnd_bcd(), 16'h0000, 1'($urandom), 1'b0);
      dec_check("R8");
    end
    for (int i = 0; i < 300; i++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom));
      full_check("R9");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule